// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped interval timer that gives software a steady periodic tick and a way to recover ticks it missed. A fixed divide-by-16 prescaler paces a 20-bit current-value counter. When that counter reaches the programmed period it returns to zero, and a 12-bit overflow tally goes up by one. A pending flag is also set. A level interrupt is raised while the flag is set and interrupts are enabled.

Software reaches four 32-bit registers through a simple single-cycle register port. A control word holds the period, a run enable and an interrupt enable. A status word shows the pending flag. Two value words return the same snapshot of the counter and the tally. Reading the first value word clears the pending flag and the tally. Reading the second one changes nothing. Because the tally accumulates between acknowledges, a late handler can see how many periods have passed. When the run enable is cleared, the counter runs on until it reaches zero and then stops, so software can poll the value until it reads zero.

Top module: `ptimer_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) every register reads zero and irq_o is low.
- R2: While the timer runs, the current value (value word bits 19:0) advances by exactly one every 16 clock cycles. Between these steps it holds still.
- R3: The control word at byte offset 0x0 holds the period in bits 19:0. On a prescaled step at which the current value is at or above the period, the current value returns to zero and the overflow tally (value word bits 31:20) increments.
- R4: The overflow tally saturates at 4095 and holds there until it is acknowledged.
- R5: A read of byte offset 0x8 returns {tally, current value} and then clears the tally and the pending flag. If a wrap occurs in the same cycle, the tally becomes 1 and the pending flag stays set.
- R6: A read of byte offset 0xC returns the same {tally, current value} snapshot and leaves the tally, the pending flag and irq_o unchanged.
- R7: Status at byte offset 0x4 bit 0 is the pending flag; it is set by every wrap and stays set until an offset-0x8 read.
- R8: irq_o is high exactly while the pending flag is set and the interrupt enable (control bit 25) is 1. With bit 25 at 0, counting and tally accumulation continue but irq_o stays low.
- R9: With the run enable (control bit 24) at 0, the counter keeps stepping until the current value is zero. It then stays at zero and no longer steps.
- R10: An offset-0x0 read returns bits 19:0, 24 and 25 as written, with all other bits zero. Writes to offsets 0x4, 0x8 and 0xC have no effect. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (when bus_sel) |
| bus_addr | input | 4 | Byte offset into the 16-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that a bus access lasts a single cycle and that the address and data stay steady through the rising edge at which they are taken. They also assume that reset is held low for at least one rising edge before any access. The bench drives every input at the falling edge and holds each access for exactly one cycle. It separates accesses with at least one idle cycle and lowers reset before the first access. It times the same-cycle acknowledge case from its own prescaler phase model, never from the design's internals.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register indices and control-bit positions for
// the periodic interval timer. Assumes a 16-byte window of 32-bit words.
package ptimer_pkg;
    localparam int PER_W   = 20;   // current value / period width
    localparam int OVF_W   = 12;   // overflow tally width
    localparam int PRE_W   = 4;    // prescaler width (divide by 2**PRE_W)
    localparam int DATA_W  = 32;   // bus data width
    localparam int EN_BIT  = 24;   // run enable position in control word
    localparam int IEN_BIT = 25;   // interrupt enable position

    // word index = byte offset [3:2]
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_ACK  = 2'd2,
        REG_PEEK = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/ptimer_prescale.sv
`timescale 1ns/1ps
// Prescaler: free counter that emits a one-cycle step pulse once every
// 2**PRE_W cycles while active_i is high; held at zero while inactive.
// Assumes PRE_W >= 1 so consecutive pulses are never adjacent.
module ptimer_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic tick_o
);
    logic [PRE_W-1:0] cnt_q;

    // pulse on the last phase of the division
    assign tick_o = active_i && (cnt_q == {PRE_W{1'b1}});

    // advance phase while active, park at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (!active_i) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // R2: step pulses are spaced apart
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/ptimer_counter.sv
`timescale 1ns/1ps
// Current-value counter: on each step pulse it increments, or returns to
// zero when at or above the period, flagging a wrap in that cycle.
// Assumes tick_i is a single-cycle pulse.
module ptimer_counter #(
    parameter int PER_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    output logic [PER_W-1:0] cur_o,
    output logic             wrap_o
);
    logic [PER_W-1:0] cur_q;

    assign cur_o  = cur_q;
    // a wrap is a step taken from the period (or beyond, after a shrink)
    assign wrap_o = tick_i && (cur_q >= period_i);

    // step or wrap the current value
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_q <= '0;
        else if (wrap_o) cur_q <= '0;
        else if (tick_i) cur_q <= cur_q + 1'b1;
    end

    // R2: value is frozen between steps
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cur_q));
    // R2: a non-wrapping step adds exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cur_q < period_i) |=> (cur_q == $past(cur_q) + 1'b1));
    // R3: a wrapping step lands on zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cur_q >= period_i) |=> (cur_q == '0));
endmodule

// File: rtl/ptimer_events.sv
`timescale 1ns/1ps
// Event keeper: saturating overflow tally and sticky pending flag.
// An acknowledge clears both, but a wrap in the same cycle survives.
module ptimer_events #(
    parameter int OVF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic             ack_i,
    output logic [OVF_W-1:0] ovf_o,
    output logic             pend_o
);
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};
    localparam logic [OVF_W-1:0] OVF_ONE = {{(OVF_W-1){1'b0}}, 1'b1};

    logic [OVF_W-1:0] ovf_q;
    logic             pend_q;

    assign ovf_o  = ovf_q;
    assign pend_o = pend_q;

    // tally: restart on acknowledge, count wraps otherwise, saturate
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf_q <= '0;
        else if (ack_i)                      ovf_q <= wrap_i ? OVF_ONE : '0;
        else if (wrap_i && ovf_q != OVF_MAX) ovf_q <= ovf_q + 1'b1;
    end

    // pending flag: set by wrap, cleared by acknowledge unless wrap coincides
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (ack_i) pend_q <= wrap_i;
        else if (wrap_i) pend_q <= 1'b1;
    end

    // R4: saturated tally holds until acknowledged
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q == OVF_MAX && !ack_i) |=> (ovf_q == OVF_MAX));
    // R5: plain acknowledge clears both
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !wrap_i) |=> (ovf_q == '0 && !pend_q));
    // R5: coinciding wrap is kept
    p_ack_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && wrap_i) |=> (ovf_q == OVF_ONE && pend_q));
    // R7: pending is sticky without acknowledge
    p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack_i) |=> pend_q);
endmodule

// File: rtl/ptimer_regs.sv
`timescale 1ns/1ps
// Register port: control word storage, read multiplexer and the
// acknowledge strobe raised by a read of the acknowledging value word.
// Assumes single-cycle accesses; address bits 1:0 are ignored.
module ptimer_regs
    import ptimer_pkg::*;
#(
    parameter int PER_W   = 20,
    parameter int OVF_W   = 12,
    parameter int DATA_W  = 32,
    parameter int EN_POS  = 24,
    parameter int IEN_POS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [3:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PER_W-1:0]  cur_i,
    input  logic [OVF_W-1:0]  ovf_i,
    input  logic              pend_i,
    output logic [PER_W-1:0]  period_o,
    output logic              en_o,
    output logic              ien_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);
    reg_idx_e         idx;
    logic             ctrl_we;
    logic [PER_W-1:0] period_q;
    logic             en_q;
    logic             ien_q;
    logic             unused_bits;

    assign idx      = reg_idx_e'(addr_i[3:2]);
    assign ctrl_we  = sel_i && wr_i && (idx == REG_CTRL);
    assign ack_o    = sel_i && !wr_i && (idx == REG_ACK);
    assign period_o = period_q;
    assign en_o     = en_q;
    assign ien_o    = ien_q;
    assign unused_bits = ^{addr_i[1:0], wdata_i};

    // control word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            en_q     <= 1'b0;
            ien_q    <= 1'b0;
        end else if (ctrl_we) begin
            period_q <= wdata_i[PER_W-1:0];
            en_q     <= wdata_i[EN_POS];
            ien_q    <= wdata_i[IEN_POS];
        end
    end

    // read multiplexer; both value words show the same snapshot
    always_comb begin
        rdata_o = '0;
        unique case (idx)
            REG_CTRL: begin
                rdata_o[PER_W-1:0] = period_q;
                rdata_o[EN_POS]    = en_q;
                rdata_o[IEN_POS]   = ien_q;
            end
            REG_STAT: rdata_o[0] = pend_i;
            REG_ACK, REG_PEEK: begin
                rdata_o[PER_W-1:0]           = cur_i;
                rdata_o[PER_W+OVF_W-1:PER_W] = ovf_i;
            end
            default: rdata_o = '0;
        endcase
    end

    // R10: control word changes only through its own write
    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> ($stable(period_q) && $stable(en_q) && $stable(ien_q)));
endmodule

// File: rtl/ptimer_top.sv
`timescale 1ns/1ps
// Periodic interval timer top: prescaler paces the current-value counter,
// wraps feed the tally and pending flag, and the register port exposes it.
// The counter stays active while enabled or while not yet back at zero.
module ptimer_top
    import ptimer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] cur;
    logic [OVF_W-1:0] ovf;
    logic             en, ien, ack, pend, tick, wrap, active;

    // run on while enabled, or drain to zero after disable
    assign active = en || (cur != '0);
    // level request gated by interrupt enable
    assign irq_o  = pend && ien;

    ptimer_regs #(
        .PER_W(PER_W), .OVF_W(OVF_W), .DATA_W(DATA_W),
        .EN_POS(EN_BIT), .IEN_POS(IEN_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .cur_i(cur), .ovf_i(ovf), .pend_i(pend),
        .period_o(period), .en_o(en), .ien_o(ien), .ack_o(ack),
        .rdata_o(bus_rdata)
    );

    ptimer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .active_i(active), .tick_o(tick)
    );

    ptimer_counter #(.PER_W(PER_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .period_i(period),
        .cur_o(cur), .wrap_o(wrap)
    );

    ptimer_events #(.OVF_W(OVF_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .ack_i(ack),
        .ovf_o(ovf), .pend_o(pend)
    );

    // R9: a disabled counter at zero stays at zero
    p_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && cur == '0) |=> (cur == '0));
    // R7: every wrap leaves the flag set
    p_wrap_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pend);
    // R1: reset leaves the request low
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !irq_o);
endmodule

// File: tb/ptimer_top_bench.sv
`timescale 1ns/1ps
module ptimer_top_bench;
    logic        clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ptimer_top u_ptimer_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    // behavioural reference state
    int m_pre = 0, m_cur = 0, m_per = 0, m_ovf = 0;
    bit m_en = 0, m_ien = 0, m_pend = 0;

    always @(posedge clk) begin
        bit is_ack, act, tk, wp;
        if (!rst_n) begin
            m_pre = 0; m_cur = 0; m_per = 0; m_ovf = 0;
            m_en = 0; m_ien = 0; m_pend = 0;
        end else begin
            is_ack = sel && !wr && (addr[3:2] == 2);
            act = m_en || (m_cur != 0);
            tk  = act && (m_pre == 15);
            wp  = tk && (m_cur >= m_per);
            m_pre = act ? (m_pre + 1) % 16 : 0;
            if (tk) m_cur = wp ? 0 : m_cur + 1;
            if (is_ack) begin
                m_ovf = wp ? 1 : 0; m_pend = wp;
            end else if (wp) begin
                if (m_ovf < 4095) m_ovf = m_ovf + 1;
                m_pend = 1;
            end
            if (sel && wr && addr[3:2] == 0) begin
                m_per = int'(wdata[19:0]); m_en = wdata[24]; m_ien = wdata[25];
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        logic [31:0] v = '0;
        case (a[3:2])
            2'd0: begin v[19:0] = m_per[19:0]; v[24] = m_en; v[25] = m_ien; end
            2'd1: v[0] = m_pend;
            default: begin v[19:0] = m_cur[19:0]; v[31:20] = m_ovf[11:0]; end
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison of the request line, plus watchdog
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) chk("R8 irq", {31'b0, irq}, {31'b0, m_pend && m_ien});
        if (cycles > 190000 && !done) begin
            done = 1; fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    task automatic rd_reg(input logic [3:0] a, input string tag, output logic [31:0] v);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        #1; v = rdata; chk(tag, rdata, exp_rd(a));
        @(negedge clk); sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] v, v2;

    initial begin
        idle(3); rst_n = 1;
        // R1: reset state
        rd_reg(4'h0, "R1 ctrl", v);  chk("R1 ctrl zero", v, 32'h0);
        rd_reg(4'h4, "R1 stat", v);  chk("R1 stat zero", v, 32'h0);
        rd_reg(4'hC, "R1 value", v); chk("R1 value zero", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2: 160 cycles apart gives exactly 10 steps
        wr_reg(4'h0, 32'h0100_03E8);
        idle(5);
        rd_reg(4'hC, "R2 first", v);
        idle(158);
        rd_reg(4'hC, "R2 second", v2);
        chk("R2 ten steps", v2[19:0] - v[19:0], 32'd10);

        // R3/R7/R8: short period, interrupts masked
        wr_reg(4'h0, 32'h0100_0002);
        idle(200);
        rd_reg(4'h4, "R7 stat set", v); chk("R7 pend", v, 32'h1);
        chk("R8 masked irq", {31'b0, irq}, 32'h0);
        rd_reg(4'hC, "R3 tally", v);
        chk("R3 current within period", {31'b0, v[19:0] <= 20'd2}, 32'h1);
        chk("R3 tally nonzero", {31'b0, v[31:20] != 0}, 32'h1);

        // R6: peek leaves state alone
        rd_reg(4'hC, "R6 peek", v);
        rd_reg(4'h4, "R6 stat after peek", v); chk("R6 pend kept", v, 32'h1);

        // R5: acknowledge clears
        rd_reg(4'h8, "R5 ack", v);
        rd_reg(4'h4, "R5 stat after ack", v);
        rd_reg(4'hC, "R5 value after ack", v);

        // R8: enable request
        wr_reg(4'h0, 32'h0300_0002);
        idle(60);
        chk("R8 irq on", {31'b0, irq}, {31'b0, m_pend});
        rd_reg(4'h8, "R8 ack", v);
        chk("R8 irq cleared", {31'b0, irq}, {31'b0, m_pend});

        // R9: disable drains to zero then stops
        wr_reg(4'h0, 32'h0000_0009);
        v = 32'hFFFF;
        for (int i = 0; i < 40 && v[19:0] != 0; i++) begin
            idle(8); rd_reg(4'hC, "R9 drain", v);
        end
        chk("R9 reached zero", {12'b0, v[19:0]}, 32'h0);
        idle(60);
        rd_reg(4'hC, "R9 stays zero", v); chk("R9 cur zero", {12'b0, v[19:0]}, 32'h0);

        // R10: ignored writes and readback
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h0, "R10 readback", v); chk("R10 mask", v, 32'h030F_FFFF);
        wr_reg(4'h0, 32'h0000_0005);
        wr_reg(4'h4, 32'hFFFF_FFFF);
        wr_reg(4'h8, 32'hFFFF_FFFF);
        wr_reg(4'hD, 32'hFFFF_FFFF);
        rd_reg(4'h3, "R10 ctrl kept", v); chk("R10 ctrl value", v, 32'h0000_0005);

        // R5: acknowledge in the same cycle as a wrap (period 0 wraps every step)
        wr_reg(4'h0, 32'h0100_0000);
        idle(40);
        do @(negedge clk); while (!(m_pre == 15));
        sel = 1; wr = 0; addr = 4'h8;
        #1; chk("R5 coincide read", rdata, exp_rd(4'h8));
        @(negedge clk); sel = 0;
        rd_reg(4'hC, "R5 coincide value", v); chk("R5 tally one", {20'b0, v[31:20]}, 32'h1);
        rd_reg(4'h4, "R5 coincide stat", v); chk("R5 pend kept", v, 32'h1);

        // R4: saturation
        rd_reg(4'h8, "R4 pre ack", v);
        idle(4100 * 16);
        rd_reg(4'hC, "R4 saturated", v); chk("R4 tally max", {20'b0, v[31:20]}, 32'd4095);
        idle(40);
        rd_reg(4'hC, "R4 held", v); chk("R4 tally held", {20'b0, v[31:20]}, 32'd4095);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule